// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block is the feedback divider of a frequency synthesiser loop. It divides an input clock by a 15-bit ratio N and emits one single-clock pulse per N input clocks. A companion output changes level on every pulse, which gives the output rate divided by two for a test port.

Inside, a dual-modulus prescaler divides by 17 or by 16. A main counter counts M prescaler cycles. A swallow counter keeps the modulus at 17 for the first A of those cycles. M is ratio bits 14..4 and A is ratio bits 3..0, so one output period lasts 17·A + 16·(M−A) = 16·M + A clocks.

The ratio input is sampled only at the edge where a period ends, so a value that changes mid-period never shortens or lengthens the period already running. Ratios below the legal floor of 240 are raised to 240. This keeps M ≥ A, which the swallow scheme needs.

Top module: `swallow_divider`

## Requirements
- R1: While rst_n is low, pulse_o and half_o are 0. The first pulse_o high appears on the first rising clock edge after rst_n goes high.
- R2: pulse_o is high for exactly one clock per output period. The period is the number of clock edges between two consecutive edges at which pulse_o goes high.
- R3: For 240 ≤ ratio_i ≤ 32767 the period is 16·ratio_i[14:4] + ratio_i[3:0] clocks, which equals the ratio value. This holds at both ends of the range.
- R4: A ratio_i value below 240, including 0, gives a period of 240 clocks.
- R5: The value on ratio_i just before the edge at which pulse_o goes high sets the length of the period that ends at the next pulse. Changes to ratio_i at any other time have no effect on the running period.
- R6: half_o inverts on every edge at which pulse_o goes high, and holds its level otherwise. Its reset value is 0.
- R7: Within a period the prescaler runs A cycles of 17 clocks followed by M−A cycles of 16 clocks. The swallow count never exceeds the remaining main count.
- R8: No prescaler cycle lasts anything other than 16 or 17 clocks, and the main count never reaches zero, so no runt or stretched output period occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_i | input | 15 | Requested division ratio N (bits 14..4 = M, bits 3..0 = A) |
| pulse_o | output | 1 | One-clock pulse per N input clocks |
| half_o | output | 1 | Level that inverts on each pulse (output rate divided by two) |

## Verification
Two things can happen in the same clock: the end of a period, where the next ratio is captured and the counters reload, and a change on ratio_i. The bench changes ratio_i at random points, sometimes inside a period and sometimes on the clock just before a terminal edge. It predicts each period from the ratio value that was present at the pulse edge. Every measured period is compared with that prediction, so a reload that picks up the value too early or too late, or one that truncates the running period, shows up as a wrong period length. Clamped values and the extremes 240 and 32767 go through the same comparison.

// File: rtl/swd_pkg.sv
package swd_pkg;
    typedef enum logic {
        MOD_LOW  = 1'b0,
        MOD_HIGH = 1'b1
    } swd_mod_e;
endpackage

// File: rtl/swd_ratio_gate.sv
module swd_ratio_gate #(
    parameter int unsigned RATIO_W   = 15,
    parameter int unsigned PRE_W     = 4,
    parameter int unsigned MIN_RATIO = 240,
    localparam int unsigned MAIN_W   = RATIO_W - PRE_W
) (
    input  logic [RATIO_W-1:0] ratio_i,
    output logic [MAIN_W-1:0]  main_o,
    output logic [PRE_W-1:0]   swallow_o
);
    localparam logic [RATIO_W-1:0] FLOOR = RATIO_W'(MIN_RATIO);

    logic [RATIO_W-1:0] eff;

    always_comb begin
        eff = (ratio_i < FLOOR) ? FLOOR : ratio_i;
    end

    assign main_o    = eff[RATIO_W-1:PRE_W];
    assign swallow_o = eff[PRE_W-1:0];
endmodule

// File: rtl/swd_prescaler.sv
module swd_prescaler
    import swd_pkg::*;
#(
    parameter int unsigned PRE_W = 4,
    localparam int unsigned PC_W = PRE_W + 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  swd_mod_e mod_i,
    output logic     tc_o
);
    localparam logic [PC_W-1:0] RELOAD_HI = PC_W'(2 ** PRE_W);
    localparam logic [PC_W-1:0] RELOAD_LO = PC_W'(2 ** PRE_W - 1);

    typedef struct packed {
        logic [PC_W-1:0] cnt;
    } pre_s;

    pre_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == '0) begin
            st_d.cnt = (mod_i == MOD_HIGH) ? RELOAD_HI : RELOAD_LO;
        end else begin
            st_d.cnt = st_q.cnt - PC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tc_o = (st_q.cnt == '0);

    assert_pre_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= RELOAD_HI);
endmodule

// File: rtl/swd_swallow.sv
module swd_swallow
    import swd_pkg::*;
#(
    parameter int unsigned RATIO_W   = 15,
    parameter int unsigned PRE_W     = 4,
    parameter int unsigned MIN_RATIO = 240,
    localparam int unsigned MAIN_W   = RATIO_W - PRE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tc_i,
    input  logic [MAIN_W-1:0] load_main_i,
    input  logic [PRE_W-1:0]  load_swallow_i,
    output swd_mod_e          mod_o,
    output logic              pulse_o,
    output logic              half_o
);
    typedef struct packed {
        logic [MAIN_W-1:0] main;
        logic [PRE_W-1:0]  swallow;
        logic              pulse;
        logic              half;
    } sw_s;

    sw_s  st_d, st_q;
    logic period_end;

    assign period_end = tc_i && (st_q.main == MAIN_W'(1));

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (period_end) begin
            st_d.main    = load_main_i;
            st_d.swallow = load_swallow_i;
            st_d.pulse   = 1'b1;
            st_d.half    = ~st_q.half;
        end else if (tc_i) begin
            st_d.main    = st_q.main - MAIN_W'(1);
            st_d.swallow = (st_q.swallow != '0) ? st_q.swallow - PRE_W'(1) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.main    <= MAIN_W'(1);
            st_q.swallow <= '0;
            st_q.pulse   <= 1'b0;
            st_q.half    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mod_o   = (st_d.swallow != '0) ? MOD_HIGH : MOD_LOW;
    assign pulse_o = st_q.pulse;
    assign half_o  = st_q.half;

    // Checker-only measurement of prescaler cycle length
    logic [PRE_W+1:0] chk_gap_q;
    logic             chk_long_q;
    logic             chk_arm_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_gap_q  <= '0;
            chk_long_q <= 1'b0;
            chk_arm_q  <= 1'b0;
        end else if (tc_i) begin
            chk_gap_q  <= (PRE_W+2)'(1);
            chk_long_q <= (mod_o == MOD_HIGH);
            chk_arm_q  <= 1'b1;
        end else begin
            chk_gap_q  <= chk_gap_q + (PRE_W+2)'(1);
        end
    end

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

    assert_half_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_o |-> $stable(half_o));

    assert_swallow_le_main_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.swallow <= PRE_W'(st_q.main) || st_q.main >= MAIN_W'(2 ** PRE_W));

    assert_sub_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_i && chk_arm_q) |->
            (int'(chk_gap_q) == (chk_long_q ? 2 ** PRE_W + 1 : 2 ** PRE_W)));

    assert_main_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.main != '0);

    assert_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> (int'(st_q.main) * (2 ** PRE_W) + int'(st_q.swallow) >= int'(MIN_RATIO)));
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
    import swd_pkg::*;
#(
    parameter int unsigned RATIO_W   = 15,
    parameter int unsigned PRE_W     = 4,
    parameter int unsigned MIN_RATIO = 240
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               pulse_o,
    output logic               half_o
);
    localparam int unsigned MAIN_W = RATIO_W - PRE_W;

    logic [MAIN_W-1:0] main_w;
    logic [PRE_W-1:0]  swallow_w;
    logic              tc_w;
    swd_mod_e          mod_w;

    swd_ratio_gate #(
        .RATIO_W   (RATIO_W),
        .PRE_W     (PRE_W),
        .MIN_RATIO (MIN_RATIO)
    ) u_gate (
        .ratio_i   (ratio_i),
        .main_o    (main_w),
        .swallow_o (swallow_w)
    );

    swd_prescaler #(
        .PRE_W (PRE_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .mod_i (mod_w),
        .tc_o  (tc_w)
    );

    swd_swallow #(
        .RATIO_W   (RATIO_W),
        .PRE_W     (PRE_W),
        .MIN_RATIO (MIN_RATIO)
    ) u_sw (
        .clk            (clk),
        .rst_n          (rst_n),
        .tc_i           (tc_w),
        .load_main_i    (main_w),
        .load_swallow_i (swallow_w),
        .mod_o          (mod_w),
        .pulse_o        (pulse_o),
        .half_o         (half_o)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !pulse_o);
endmodule

// File: tb/sim_swallow_divider.sv
module sim_swallow_divider;
    localparam int CLK_P = 10;
    localparam int MINR  = 240;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] ratio_r = 15'd240;
    logic        pulse_o, half_o;

    int checks = 0;
    int errors = 0;

    swallow_divider u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .ratio_i (ratio_r),
        .pulse_o (pulse_o),
        .half_o  (half_o)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic int exp_period(input logic [14:0] r);
        int n;
        n = 16 * int'(r[14:4]) + int'(r[3:0]);
        return (n < MINR) ? MINR : n;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // edge bookkeeping
    int          cyc = 0;
    int          live_edges = 0;
    logic [14:0] ratio_at_edge;
    always @(posedge clk) begin
        cyc           <= cyc + 1;
        ratio_at_edge <= ratio_r;
        if (rst_n) live_edges <= live_edges + 1;
    end

    // monitor
    bit          seen = 0;
    int          last_cyc = 0;
    int          exp_next = 0;
    logic [14:0] raw_next = '0;
    logic [14:0] raw_prev = '0;
    bit          exp_half = 0;
    bit          prev_pulse = 0;
    int          pulses = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            check(pulse_o == 1'b0 && half_o == 1'b0, "R1 reset", {pulse_o, half_o}, 0);
        end else begin
            if (live_edges == 1)
                check(pulse_o == 1'b1, "R1 first pulse", pulse_o, 1);
            if (prev_pulse)
                check(pulse_o == 1'b0, "R2 width", pulse_o, 0);
            if (pulse_o) begin
                exp_half = ~exp_half;
                if (seen) begin
                    if (raw_next < 15'(MINR))
                        check(cyc - last_cyc == exp_next, "R4 clamp period", cyc - last_cyc, exp_next);
                    else if (raw_next != raw_prev)
                        check(cyc - last_cyc == exp_next, "R5 new ratio period", cyc - last_cyc, exp_next);
                    else
                        check(cyc - last_cyc == exp_next, "R3 R7 R8 period", cyc - last_cyc, exp_next);
                end
                raw_prev = raw_next;
                raw_next = ratio_at_edge;
                exp_next = exp_period(ratio_at_edge);
                last_cyc = cyc;
                seen     = 1;
                pulses++;
            end
            check(half_o == exp_half, "R6 half level", half_o, exp_half);
            prev_pulse = pulse_o;
        end
    end

    task automatic wait_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!pulse_o) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_P * 195000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R3 minimum ratio
        wait_pulses(5);
        // R3 maximum ratio
        ratio_r = 15'd32767;
        wait_pulses(3);
        // R4 clamped values
        ratio_r = 15'd100;  wait_pulses(3);
        ratio_r = 15'd0;    wait_pulses(2);
        ratio_r = 15'd239;  wait_pulses(2);
        // R7 large swallow count and zero swallow count
        ratio_r = 15'd287;  wait_pulses(3);
        ratio_r = 15'd256;  wait_pulses(3);
        // R5 changes just before a terminal edge
        ratio_r = 15'd300;  wait_pulses(2);
        repeat (298) @(negedge clk);
        ratio_r = 15'd411;
        wait_pulses(3);
        // R5 random ratios changed at random points
        for (int k = 0; k < 30; k++) begin
            repeat ($urandom_range(1, 2000)) @(negedge clk);
            ratio_r = 15'($urandom_range(150, 3000));
            if ((k % 4) == 0) begin
                repeat ($urandom_range(1, 50)) @(negedge clk);
                ratio_r = 15'($urandom_range(230, 2500));
            end
        end
        wait_pulses(3);
        finish_run();
    end
endmodule